// File: doc/BRIEF.md
# Region Vector Tag Array

This block stands in place of the tag array of a large shared cache. It tracks coarse regions instead of single blocks. Each region entry holds a region tag and one location field for every cache block in the region; a location field says whether that block is resident and, if so, which way of the data array holds it. The entries sit in a set-associative array. One lookup on a physical address reports three things: whether the region is tracked, which of its blocks are resident, and the data way of each resident block.

An update port carries four operations. Allocate installs a region. Set block and clear block write one location field. Invalidate drops a whole region in one step. When allocation has to replace a live region entry, the whole victim (tag, set and every location field) is handed out on an eviction stream. A downstream buffer can then retire its blocks over time. The default geometry is small enough to elaborate as flops. A full-size build overrides the parameters to 2048 sets of 12 ways with 50-bit addresses, 64-byte blocks, 1 KB regions and a 16-way data array.

The eviction output is a valid/ready stream. A victim is held stable while `ev_valid` is high and `ev_ready` is low. During that time `op_ready` is low, so no update of any kind is taken. The lookup path has no back-pressure: a lookup is always accepted, and its result is shown for exactly one cycle.

Top module: `region_vector_tags`

## Requirements
- R1: After reset every entry is invalid: lookups miss with an all-zero mask, `ev_valid` is 0 and `op_ready` is 1.
- R2: A lookup taken with `lk_valid` gives `rs_valid`=1 in the next cycle only. `rs_hit` is 1 when a valid entry in the set picked by the address holds the address's region tag.
- R3: On a hit, bit i of `rs_mask` is 1 when block i of the region is resident, and `rs_ways[4i+3:4i]` gives its data way. On a miss the mask is zero.
- R4: `op_code`=0 (allocate) for an absent region installs it with every block absent. For a present region it changes nothing.
- R5: `op_code`=1 (set block) marks block `op_addr[9:6]` resident in way `op_dway`. `op_code`=2 (clear block) marks it absent. Both are ignored when the region is not tracked.
- R6: `op_code`=3 (invalidate) removes a tracked region, so later lookups miss. It produces no eviction.
- R7: Allocation uses the lowest-index invalid way of the set. With no invalid way, it uses the lowest-index way whose recently-used bit is clear. A way's recently-used bit is set by an allocate into it, by a set or clear that hits it, and by a lookup hit. The lookup hit sets it at the edge that ends the result cycle. If setting a bit would set all bits, only the touched way's bit remains set.
- R8: Replacing a valid entry raises `ev_valid` in the cycle after the allocate. It carries the victim's tag, set, residency mask and ways, held stable until `ev_ready`. The replaced region then misses.
- R9: While `ev_valid`=1 and `ev_ready`=0, `op_ready` is 0 and no operation is taken.
- R10: A lookup in the same cycle as an accepted update to the same set returns the contents after that update.
- R11: Allocating a region that is already tracked never creates a second entry for it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| lk_valid | input | 1 | Lookup request |
| lk_addr | input | ADDR_W | Lookup physical address |
| rs_valid | output | 1 | Lookup result present |
| rs_hit | output | 1 | Region tracked |
| rs_mask | output | NBLK | Resident-block mask |
| rs_ways | output | NBLK*DW_W | Data way per block |
| op_valid | input | 1 | Update request |
| op_ready | output | 1 | Update accepted this cycle |
| op_code | input | 2 | 0 allocate, 1 set block, 2 clear block, 3 invalidate |
| op_addr | input | ADDR_W | Update address |
| op_dway | input | DW_W | Data way for set block |
| ev_valid | output | 1 | Victim entry present |
| ev_ready | input | 1 | Victim taken |
| ev_tag | output | TAG_W | Victim region tag |
| ev_set | output | SET_W | Victim set index |
| ev_mask | output | NBLK | Victim resident-block mask |
| ev_ways | output | NBLK*DW_W | Victim data way per block |

## Verification
A corrupted location field shows in the mask or way bits of the next lookup to that region, one cycle after the lookup is issued. A fault in the recently-used bits or in the invalid-way preference stays hidden until a later allocate fills the set. It then shows as the wrong tag on the eviction stream, or as an eviction where none should occur. A duplicate entry or a lost invalidation shows as a lookup that hits when it should miss. A fault in the stall path shows as a victim that changes, or an operation that is taken, while `ev_ready` is low.

// File: rtl/rvt_pkg.sv
package rvt_pkg;
  typedef enum logic [1:0] {
    RVT_ALLOC = 2'd0,
    RVT_SET   = 2'd1,
    RVT_CLR   = 2'd2,
    RVT_INV   = 2'd3
  } rvt_op_e;
endpackage

// File: rtl/rvt_match.sv
module rvt_match #(
  parameter int WAYS  = 12,
  parameter int TAG_W = 29,
  localparam int WI_W = (WAYS > 1) ? $clog2(WAYS) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [TAG_W-1:0] tags [WAYS],
  input  logic [WAYS-1:0]  valid,
  input  logic [TAG_W-1:0] key,
  output logic             hit,
  output logic [WI_W-1:0]  idx
);
  logic [WAYS-1:0] hit_vec;

  for (genvar w = 0; w < WAYS; w++) begin : g_cmp
    assign hit_vec[w] = valid[w] && (tags[w] == key);
  end

  always_comb begin
    idx = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (hit_vec[w]) idx = WI_W'(w);
    end
  end

  assign hit = |hit_vec;

  AST_ONE_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit_vec)); // R11
endmodule

// File: rtl/rvt_victim.sv
module rvt_victim #(
  parameter int WAYS = 12,
  localparam int WI_W = (WAYS > 1) ? $clog2(WAYS) : 1
) (
  input  logic [WAYS-1:0] valid,
  input  logic [WAYS-1:0] mru,
  output logic [WI_W-1:0] way
);
  logic found;

  always_comb begin
    way   = '0;
    found = 1'b0;
    for (int w = 0; w < WAYS; w++) begin
      if (!found && !valid[w]) begin
        way   = WI_W'(w);
        found = 1'b1;
      end
    end
    for (int w = 0; w < WAYS; w++) begin
      if (!found && !mru[w]) begin
        way   = WI_W'(w);
        found = 1'b1;
      end
    end
  end
endmodule

// File: rtl/region_vector_tags.sv
module region_vector_tags
  import rvt_pkg::*;
#(
  parameter int ADDR_W = 50,
  parameter int BLK_B  = 64,
  parameter int NBLK   = 16,
  parameter int SETS   = 128,
  parameter int WAYS   = 12,
  parameter int DWAYS  = 16,
  localparam int OFF_W = $clog2(BLK_B),
  localparam int BIR_W = $clog2(NBLK),
  localparam int SET_W = $clog2(SETS),
  localparam int DW_W  = $clog2(DWAYS),
  localparam int WI_W  = (WAYS > 1) ? $clog2(WAYS) : 1,
  localparam int TAG_W = ADDR_W - OFF_W - BIR_W - SET_W,
  localparam int TAG_LSB = OFF_W + BIR_W + SET_W
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 lk_valid,
  input  logic [ADDR_W-1:0]    lk_addr,
  output logic                 rs_valid,
  output logic                 rs_hit,
  output logic [NBLK-1:0]      rs_mask,
  output logic [NBLK*DW_W-1:0] rs_ways,
  input  logic                 op_valid,
  output logic                 op_ready,
  input  logic [1:0]           op_code,
  input  logic [ADDR_W-1:0]    op_addr,
  input  logic [DW_W-1:0]      op_dway,
  output logic                 ev_valid,
  input  logic                 ev_ready,
  output logic [TAG_W-1:0]     ev_tag,
  output logic [SET_W-1:0]     ev_set,
  output logic [NBLK-1:0]      ev_mask,
  output logic [NBLK*DW_W-1:0] ev_ways
);
  // entry storage
  logic [TAG_W-1:0]     tag_q  [SETS][WAYS];
  logic [WAYS-1:0]      vld_q  [SETS];
  logic [WAYS-1:0]      mru_q  [SETS];
  logic [NBLK-1:0]      fldv_q [SETS][WAYS];
  logic [NBLK*DW_W-1:0] fldw_q [SETS][WAYS];

  // address split
  logic [TAG_W-1:0] lk_tag, op_tag;
  logic [SET_W-1:0] lk_set, op_set;
  logic [BIR_W-1:0] op_blk;
  logic             unused_addr_bits;

  assign lk_tag = lk_addr[ADDR_W-1:TAG_LSB];
  assign lk_set = lk_addr[TAG_LSB-1:OFF_W+BIR_W];
  assign op_tag = op_addr[ADDR_W-1:TAG_LSB];
  assign op_set = op_addr[TAG_LSB-1:OFF_W+BIR_W];
  assign op_blk = op_addr[OFF_W+BIR_W-1:OFF_W];
  assign unused_addr_bits = ^{lk_addr[OFF_W+BIR_W-1:0], op_addr[OFF_W-1:0]};

  // lookup stage register; array read happens in the result cycle
  logic             lk_v_q;
  logic [TAG_W-1:0] lk_tag_q;
  logic [SET_W-1:0] lk_set_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lk_v_q   <= 1'b0;
      lk_tag_q <= '0;
      lk_set_q <= '0;
    end else begin
      lk_v_q <= lk_valid;
      if (lk_valid) begin
        lk_tag_q <= lk_tag;
        lk_set_q <= lk_set;
      end
    end
  end

  logic            lk_hit;
  logic [WI_W-1:0] lk_hw;

  rvt_match #(.WAYS(WAYS), .TAG_W(TAG_W)) u_lk_match (
    .clk   (clk),
    .rst_n (rst_n),
    .tags  (tag_q[lk_set_q]),
    .valid (vld_q[lk_set_q]),
    .key   (lk_tag_q),
    .hit   (lk_hit),
    .idx   (lk_hw)
  );

  assign rs_valid = lk_v_q;
  assign rs_hit   = lk_v_q && lk_hit;
  assign rs_mask  = rs_hit ? fldv_q[lk_set_q][lk_hw] : '0;
  assign rs_ways  = rs_hit ? fldw_q[lk_set_q][lk_hw] : '0;

  // update path
  logic            op_hit;
  logic [WI_W-1:0] op_hw, op_vw;
  rvt_op_e         op_kind;
  logic            op_fire;

  assign op_kind  = rvt_op_e'(op_code);
  assign op_ready = !ev_valid || ev_ready;
  assign op_fire  = op_valid && op_ready;

  rvt_match #(.WAYS(WAYS), .TAG_W(TAG_W)) u_op_match (
    .clk   (clk),
    .rst_n (rst_n),
    .tags  (tag_q[op_set]),
    .valid (vld_q[op_set]),
    .key   (op_tag),
    .hit   (op_hit),
    .idx   (op_hw)
  );

  rvt_victim #(.WAYS(WAYS)) u_victim (
    .valid (vld_q[op_set]),
    .mru   (mru_q[op_set]),
    .way   (op_vw)
  );

  logic do_alloc, do_set, do_clr, do_inv, do_evict;

  assign do_alloc = op_fire && (op_kind == RVT_ALLOC) && !op_hit;
  assign do_set   = op_fire && (op_kind == RVT_SET) && op_hit;
  assign do_clr   = op_fire && (op_kind == RVT_CLR) && op_hit;
  assign do_inv   = op_fire && (op_kind == RVT_INV) && op_hit;
  assign do_evict = do_alloc && vld_q[op_set][op_vw];

  // data fields (no reset needed: guarded by valid bits)
  always_ff @(posedge clk) begin
    if (do_alloc) begin
      tag_q[op_set][op_vw]  <= op_tag;
      fldv_q[op_set][op_vw] <= '0;
    end
    if (do_set) begin
      fldv_q[op_set][op_hw][op_blk] <= 1'b1;
      fldw_q[op_set][op_hw][op_blk*DW_W +: DW_W] <= op_dway;
    end
    if (do_clr) fldv_q[op_set][op_hw][op_blk] <= 1'b0;
    if (do_inv) fldv_q[op_set][op_hw] <= '0;
  end

  // valid bits
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++) vld_q[s] <= '0;
    end else begin
      if (do_alloc) vld_q[op_set][op_vw] <= 1'b1;
      if (do_inv)   vld_q[op_set][op_hw] <= 1'b0;
    end
  end

  // recently-used bits
  function automatic logic [WAYS-1:0] mru_touch(input logic [WAYS-1:0] m,
                                                input logic [WI_W-1:0] w);
    logic [WAYS-1:0] oh;
    logic [WAYS-1:0] t;
    oh    = '0;
    oh[w] = 1'b1;
    t     = m | oh;
    return (&t) ? oh : t;
  endfunction

  logic            op_touch, lk_touch, same_set;
  logic [WI_W-1:0] op_tw;

  assign op_touch = do_alloc || do_set || do_clr ||
                    (op_fire && (op_kind == RVT_ALLOC) && op_hit);
  assign op_tw    = do_alloc ? op_vw : op_hw;
  assign lk_touch = lk_v_q && lk_hit;
  assign same_set = lk_touch && (lk_set_q == op_set);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++) mru_q[s] <= '0;
    end else begin
      if (op_touch)
        mru_q[op_set] <= mru_touch(same_set ? mru_touch(mru_q[op_set], lk_hw)
                                            : mru_q[op_set], op_tw);
      if (lk_touch && !(op_touch && same_set))
        mru_q[lk_set_q] <= mru_touch(mru_q[lk_set_q], lk_hw);
    end
  end

  // eviction stream register
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ev_valid <= 1'b0;
      ev_tag   <= '0;
      ev_set   <= '0;
      ev_mask  <= '0;
      ev_ways  <= '0;
    end else if (do_evict) begin
      ev_valid <= 1'b1;
      ev_tag   <= tag_q[op_set][op_vw];
      ev_set   <= op_set;
      ev_mask  <= fldv_q[op_set][op_vw];
      ev_ways  <= fldw_q[op_set][op_vw];
    end else if (ev_ready) begin
      ev_valid <= 1'b0;
    end
  end

  AST_RS_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    lk_valid |=> rs_valid); // R2
  AST_RS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_valid |=> !rs_valid); // R2
  AST_EV_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_valid && !ev_ready) |=> (ev_valid && $stable(ev_tag) && $stable(ev_set)
                                 && $stable(ev_mask) && $stable(ev_ways))); // R8
  AST_EV_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ev_valid) |-> $past(op_valid && op_ready && (op_code == 2'd0))); // R8
  AST_INV_MISS: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_ready && (op_code == 2'd3) && lk_valid &&
     (lk_addr[ADDR_W-1:OFF_W+BIR_W] == op_addr[ADDR_W-1:OFF_W+BIR_W]))
    |=> (rs_valid && !rs_hit)); // R6
endmodule

// File: tb/sim_region_vector_tags.sv
module sim_region_vector_tags;
  localparam int TW = 38;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        lk_valid = 1'b0;
  logic [49:0] lk_addr = '0;
  logic        rs_valid, rs_hit;
  logic [15:0] rs_mask;
  logic [63:0] rs_ways;
  logic        op_valid = 1'b0;
  logic        op_ready;
  logic [1:0]  op_code = '0;
  logic [49:0] op_addr = '0;
  logic [3:0]  op_dway = '0;
  logic        ev_valid;
  logic        ev_ready = 1'b0;
  logic [TW-1:0] ev_tag;
  logic [1:0]  ev_set;
  logic [15:0] ev_mask;
  logic [63:0] ev_ways;

  region_vector_tags #(.SETS(4), .WAYS(4)) u0 (
    .clk(clk), .rst_n(rst_n),
    .lk_valid(lk_valid), .lk_addr(lk_addr),
    .rs_valid(rs_valid), .rs_hit(rs_hit), .rs_mask(rs_mask), .rs_ways(rs_ways),
    .op_valid(op_valid), .op_ready(op_ready), .op_code(op_code),
    .op_addr(op_addr), .op_dway(op_dway),
    .ev_valid(ev_valid), .ev_ready(ev_ready), .ev_tag(ev_tag), .ev_set(ev_set),
    .ev_mask(ev_mask), .ev_ways(ev_ways)
  );

  always #5 clk = ~clk;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [49:0] mk(input logic [7:0] tg, input logic [1:0] st,
                                     input logic [3:0] bk);
    return {30'd0, tg, st, bk, 6'd0};
  endfunction

  task automatic do_op(input logic [1:0] code, input logic [49:0] a, input logic [3:0] dw);
    op_valid = 1'b1; op_code = code; op_addr = a; op_dway = dw;
    @(negedge clk);
    op_valid = 1'b0;
  endtask

  // lookup, sample at result, then one idle cycle so the recency touch lands
  task automatic do_lk(input logic [49:0] a);
    lk_valid = 1'b1; lk_addr = a;
    @(negedge clk);
    lk_valid = 1'b0;
  endtask

  task automatic drain();
    ev_ready = 1'b1;
    @(negedge clk);
    ev_ready = 1'b0;
  endtask

  typedef struct packed {
    logic [2:0]  kind;   // 0..3 op codes, 4 lookup
    logic [7:0]  tag;
    logic [1:0]  set;
    logic [3:0]  blk;
    logic [3:0]  dway;
    logic        hit;
    logic [15:0] mask;
    logic [3:0]  way;
  } vec_t;

  localparam int NV = 19;
  localparam vec_t TBL [NV] = '{
    '{3'd4, 8'h11, 2'd1, 4'd0, 4'd0,  1'b0, 16'h0000, 4'd0},  // R2 miss
    '{3'd1, 8'h11, 2'd1, 4'd2, 4'd5,  1'b0, 16'h0000, 4'd0},  // R5 set on absent
    '{3'd4, 8'h11, 2'd1, 4'd2, 4'd0,  1'b0, 16'h0000, 4'd0},  // R5 still absent
    '{3'd0, 8'h11, 2'd1, 4'd0, 4'd0,  1'b0, 16'h0000, 4'd0},  // alloc
    '{3'd4, 8'h11, 2'd1, 4'd0, 4'd0,  1'b1, 16'h0000, 4'd0},  // R4 empty region
    '{3'd1, 8'h11, 2'd1, 4'd2, 4'd5,  1'b0, 16'h0000, 4'd0},
    '{3'd1, 8'h11, 2'd1, 4'd9, 4'd12, 1'b0, 16'h0000, 4'd0},
    '{3'd4, 8'h11, 2'd1, 4'd2, 4'd0,  1'b1, 16'h0204, 4'd5},  // R3
    '{3'd4, 8'h11, 2'd1, 4'd9, 4'd0,  1'b1, 16'h0204, 4'd12}, // R3
    '{3'd0, 8'h11, 2'd1, 4'd0, 4'd0,  1'b0, 16'h0000, 4'd0},  // R11 realloc
    '{3'd4, 8'h11, 2'd1, 4'd9, 4'd0,  1'b1, 16'h0204, 4'd12}, // R4 R11 kept
    '{3'd2, 8'h11, 2'd1, 4'd2, 4'd0,  1'b0, 16'h0000, 4'd0},  // clear
    '{3'd4, 8'h11, 2'd1, 4'd9, 4'd0,  1'b1, 16'h0200, 4'd12}, // R5 clear
    '{3'd0, 8'h22, 2'd1, 4'd0, 4'd0,  1'b0, 16'h0000, 4'd0},
    '{3'd1, 8'h22, 2'd1, 4'd0, 4'd3,  1'b0, 16'h0000, 4'd0},
    '{3'd4, 8'h22, 2'd1, 4'd0, 4'd0,  1'b1, 16'h0001, 4'd3},  // R3
    '{3'd3, 8'h11, 2'd1, 4'd0, 4'd0,  1'b0, 16'h0000, 4'd0},  // invalidate
    '{3'd4, 8'h11, 2'd1, 4'd9, 4'd0,  1'b0, 16'h0000, 4'd0},  // R6 miss
    '{3'd4, 8'h22, 2'd1, 4'd0, 4'd0,  1'b1, 16'h0001, 4'd3}   // R6 other kept
  };

  initial begin
    #2_000_000;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1 ev_valid", ev_valid, 0);
    chk("R1 op_ready", op_ready, 1);
    chk("R1 rs_valid idle", rs_valid, 0);
    lk_valid = 1'b1; lk_addr = mk(8'h05, 2'd2, 4'd1);
    @(negedge clk);
    lk_valid = 1'b0;
    chk("R1 hit", rs_hit, 0);
    chk("R1 mask", rs_mask, 0);
    chk("R2 rs_valid result", rs_valid, 1);
    @(negedge clk);
    chk("R2 rs_valid one cycle", rs_valid, 0);

    // table walk in set 1
    for (int i = 0; i < NV; i++) begin
      if (TBL[i].kind == 3'd4) begin
        do_lk(mk(TBL[i].tag, TBL[i].set, TBL[i].blk));
        chk($sformatf("R3 vec%0d hit", i), rs_hit, TBL[i].hit);
        chk($sformatf("R3 vec%0d mask", i), rs_mask, TBL[i].mask);
        if (TBL[i].mask[TBL[i].blk])
          chk($sformatf("R3 vec%0d way", i), rs_ways[TBL[i].blk*4 +: 4], TBL[i].way);
        @(negedge clk);
      end else begin
        do_op(TBL[i].kind[1:0], mk(TBL[i].tag, TBL[i].set, TBL[i].blk), TBL[i].dway);
      end
    end
    chk("R6 no eviction from table", ev_valid, 0);

    // R10 same-cycle update and lookup
    do_op(2'd0, mk(8'h33, 2'd2, 4'd0), 4'd0);
    op_valid = 1'b1; op_code = 2'd1; op_addr = mk(8'h33, 2'd2, 4'd4); op_dway = 4'd9;
    lk_valid = 1'b1; lk_addr = mk(8'h33, 2'd2, 4'd4);
    @(negedge clk);
    op_valid = 1'b0; lk_valid = 1'b0;
    chk("R10 hit", rs_hit, 1);
    chk("R10 mask", rs_mask, 16'h0010);
    chk("R10 way", rs_ways[19:16], 4'd9);
    @(negedge clk);

    // R7 R8 R9 replacement in set 0
    do_op(2'd0, mk(8'hA0, 2'd0, 4'd0), 4'd0);
    do_op(2'd1, mk(8'hA0, 2'd0, 4'd3), 4'd7);
    do_op(2'd1, mk(8'hA0, 2'd0, 4'd15), 4'd15);
    do_op(2'd0, mk(8'hB0, 2'd0, 4'd0), 4'd0);
    do_op(2'd0, mk(8'hC0, 2'd0, 4'd0), 4'd0);
    do_op(2'd0, mk(8'hD0, 2'd0, 4'd0), 4'd0);
    chk("R7 no eviction while invalid ways remain", ev_valid, 0);
    do_op(2'd0, mk(8'hE0, 2'd0, 4'd0), 4'd0);
    chk("R8 ev_valid", ev_valid, 1);
    chk("R7 R8 victim tag", ev_tag, {30'd0, 8'hA0});
    chk("R8 ev_set", ev_set, 0);
    chk("R8 ev_mask", ev_mask, 16'h8008);
    chk("R8 ev way blk3", ev_ways[15:12], 4'd7);
    chk("R8 ev way blk15", ev_ways[63:60], 4'd15);
    op_valid = 1'b1; op_code = 2'd0; op_addr = mk(8'hF0, 2'd0, 4'd0);
    for (int k = 0; k < 3; k++) begin
      chk("R9 op_ready low", op_ready, 0);
      @(negedge clk);
      chk("R8 ev held", ev_tag, {30'd0, 8'hA0});
    end
    ev_ready = 1'b1;
    @(negedge clk);
    op_valid = 1'b0; ev_ready = 1'b0;
    chk("R9 stalled op then taken", ev_valid, 1);
    chk("R7 second victim", ev_tag, {30'd0, 8'hB0});
    drain();
    chk("R8 drained", ev_valid, 0);
    do_lk(mk(8'hA0, 2'd0, 4'd3));
    chk("R8 replaced region misses", rs_hit, 0);
    @(negedge clk);
    do_lk(mk(8'hC0, 2'd0, 4'd0));
    chk("R7 lookup hit C", rs_hit, 1);
    @(negedge clk);
    do_op(2'd0, mk(8'h70, 2'd0, 4'd0), 4'd0);
    chk("R7 lookup touch spares C", ev_tag, {30'd0, 8'hE0});
    drain();

    // R7 invalid way preferred, set 3
    do_op(2'd0, mk(8'h40, 2'd3, 4'd0), 4'd0);
    do_op(2'd0, mk(8'h41, 2'd3, 4'd0), 4'd0);
    do_op(2'd0, mk(8'h42, 2'd3, 4'd0), 4'd0);
    do_op(2'd0, mk(8'h43, 2'd3, 4'd0), 4'd0);
    do_op(2'd3, mk(8'h41, 2'd3, 4'd0), 4'd0);
    chk("R6 invalidate no eviction", ev_valid, 0);
    do_op(2'd0, mk(8'h44, 2'd3, 4'd0), 4'd0);
    chk("R7 invalid way reused", ev_valid, 0);
    do_op(2'd0, mk(8'h45, 2'd3, 4'd0), 4'd0);
    chk("R7 victim after reuse", ev_tag, {30'd0, 8'h40});
    drain();
    do_lk(mk(8'h44, 2'd3, 4'd0));
    chk("R4 reused region hit", rs_hit, 1);
    @(negedge clk);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule